// File: doc/BRIEF.md
# Column Burst Sequencer with Clock Suspend

This block is the device side of a synchronous DRAM-style column access path. It accepts READ and WRITE commands against a small internal cell array. It steps through a burst of sequential column addresses and returns read words after a selectable read latency. The burst length and the read latency come from static configuration inputs. Change them only while no burst is running.

A clock-enable input can freeze the block in the middle of a burst. The block samples `cke` on every rising edge. A low sample suppresses the next internal edge, provided a burst is still in flight. Work counts as in flight from the accepted command until the data-output enable has dropped. On a suppressed edge the burst counter, the latency pipeline, command and data capture and the output registers all hold. When `cke` is sampled high again, work resumes on the following edge. When the block is idle, `cke` has no effect.

Top module: `sdram_burst_core`

## Requirements
- R1: While `rst` is high and after it falls, `rdata_oe` is 0 and `rdata` is 0 until the first read word is presented.
- R2: Read latency is set by `cfg_cl` (0 gives 2, 1 gives 3). The first read word is on `rdata` after the internal edge that comes that many internal edges after the edge accepting READ. Each later word follows one internal edge after the one before it. `rdata_oe` is 1 exactly while words are presented and drops one internal edge after the last word.
- R3: `cfg_bl` encodes the burst length: 00 gives 1, 01 gives 2, 10 gives 4 and 11 gives 8 words. Word i of a burst starting at column c uses column (c with its low log2(BL) bits cleared) OR ((c+i) mod BL). The bank stays fixed for the whole burst.
- R4: A WRITE stores `wdata` at the starting column on the accepting edge. It then stores one word per internal edge until BL words have been stored. `rdata_oe` stays 0 during a write burst.
- R5: A rising edge is suppressed when `cke` was low at the previous rising edge and work is in flight. On a suppressed edge the column counter, the latency pipeline, `rdata` and `rdata_oe` all hold.
- R6: Command, address and write data present at a suppressed edge are ignored and leave the array unchanged.
- R7: After `cke` is sampled high, the next rising edge is an internal edge and the burst resumes where it stopped.
- R8: When nothing is in flight, `cke` sampled low has no effect, and a command is accepted on the next edge.
- R9: `cmd` encodes 01 as READ, 10 as WRITE, and 00 or 11 as no operation. A READ or WRITE arriving while a burst's column counter is still running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable, sampled each rising edge |
| cmd | input | 2 | Command code |
| bank | input | BANK_W | Bank of the starting address |
| col | input | COL_W | Starting column |
| wdata | input | DATA_W | Write data |
| cfg_bl | input | 2 | Burst length code |
| cfg_cl | input | 1 | Read latency select (0 gives 2, 1 gives 3) |
| rdata | output | DATA_W | Read data |
| rdata_oe | output | 1 | High while a read word is presented |

## Verification
Every combination of burst length and latency is exercised with `cke` held high. This fixes the plain latency and the wrapped column order. The same bursts are then run with `cke` low 30 to 70 percent of the time. A slip of one edge in the resume, or any motion of the outputs while frozen, shows up as a misplaced or changed word. Junk commands, addresses and data are driven on suppressed edges and while the counter runs, and later readback shows whether any of them reached the array. Some commands are issued right after `cke` has been low with nothing in flight, which tells an idle block apart from a wrongly frozen one.

// File: rtl/sbe_pkg.sv
package sbe_pkg;
  typedef enum logic [1:0] {
    CMD_NOP   = 2'b00,
    CMD_READ  = 2'b01,
    CMD_WRITE = 2'b10,
    CMD_RSV   = 2'b11
  } cmd_e;

  // Number of words in a burst for a length code.
  function automatic logic [3:0] burst_words(input logic [1:0] code);
    return 4'd1 << code;
  endfunction
endpackage

// File: rtl/sbe_suspend_gate.sv
module sbe_suspend_gate (
  input  logic clk,
  input  logic rst,
  input  logic cke,
  input  logic busy,
  output logic en
);
  logic cke_q;

  always_ff @(posedge clk) begin
    if (rst) cke_q <= 1'b1;
    else     cke_q <= cke;
  end

  // An edge is suppressed only when the prior sample was low and work is in flight.
  assign en = cke_q | ~busy;
endmodule

// File: rtl/sbe_burst_ctr.sv
module sbe_burst_ctr
  import sbe_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int COL_W  = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      en,
  input  logic                      start_rd,
  input  logic                      start_wr,
  input  logic [1:0]                bl_code,
  input  logic [BANK_W-1:0]         start_bank,
  input  logic [COL_W-1:0]          start_col,
  output logic                      rd_active,
  output logic                      wr_active,
  output logic [BANK_W+COL_W-1:0]   cur_addr
);
  localparam int ADDR_W = BANK_W + COL_W;

  logic [COL_W-1:0] m_new, m_q;
  logic [3:0]       left;
  logic [ADDR_W-1:0] keep_mask;

  assign m_new     = COL_W'(burst_words(bl_code) - 4'd1);
  assign keep_mask = {{BANK_W{1'b1}}, ~m_q};

  function automatic logic [COL_W-1:0] step(input logic [COL_W-1:0] c,
                                            input logic [COL_W-1:0] m);
    return (c & ~m) | ((c + 1'b1) & m);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_active <= 1'b0;
      wr_active <= 1'b0;
      left      <= '0;
      m_q       <= '0;
      cur_addr  <= '0;
    end else if (en) begin
      if (start_rd) begin
        m_q       <= m_new;
        cur_addr  <= {start_bank, start_col};
        left      <= burst_words(bl_code);
        rd_active <= 1'b1;
      end else if (start_wr) begin
        m_q       <= m_new;
        cur_addr  <= {start_bank, step(start_col, m_new)};
        left      <= burst_words(bl_code) - 4'd1;
        wr_active <= (bl_code != 2'b00);
      end else if (rd_active || wr_active) begin
        cur_addr[COL_W-1:0] <= step(cur_addr[COL_W-1:0], m_q);
        left                <= left - 4'd1;
        if (left == 4'd1) begin
          rd_active <= 1'b0;
          wr_active <= 1'b0;
        end
      end
    end
  end

  AST_CTR_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(cur_addr) && $stable(rd_active) && $stable(wr_active))); // R5
  AST_WRAP_IN_BLOCK: assert property (@(posedge clk) disable iff (rst)
    (en && (rd_active || wr_active)) |=>
      ((cur_addr & keep_mask) == ($past(cur_addr) & keep_mask))); // R3
  AST_ONE_MODE: assert property (@(posedge clk) disable iff (rst)
    !(rd_active && wr_active)); // R9
endmodule

// File: rtl/sbe_cell_array.sv
module sbe_cell_array #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rq
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rq <= cells[raddr];
  end
endmodule

// File: rtl/sbe_read_pipe.sv
module sbe_read_pipe #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              issue,
  input  logic              cl3,
  input  logic [DATA_W-1:0] rq,
  output logic              pipe_busy,
  output logic [DATA_W-1:0] rdata,
  output logic              oe
);
  logic              v_a, v_b;
  logic [DATA_W-1:0] d_b;
  logic              out_v;
  logic [DATA_W-1:0] out_d;

  assign out_v     = cl3 ? v_b : v_a;
  assign out_d     = cl3 ? d_b : rq;
  assign pipe_busy = v_a | v_b | oe;

  always_ff @(posedge clk) begin
    if (rst) begin
      v_a   <= 1'b0;
      v_b   <= 1'b0;
      d_b   <= '0;
      rdata <= '0;
      oe    <= 1'b0;
    end else if (en) begin
      v_a <= issue;
      v_b <= v_a & cl3;
      d_b <= rq;
      oe  <= out_v;
      if (out_v) rdata <= out_d;
    end
  end

  AST_OUT_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(rdata) && $stable(oe))); // R5
  AST_OE_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
    $rose(oe) |-> $past(en)); // R7
endmodule

// File: rtl/sdram_burst_core.sv
module sdram_burst_core
  import sbe_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BANK_W = 2,
  parameter int COL_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cke,
  input  logic [1:0]        cmd,
  input  logic [BANK_W-1:0] bank,
  input  logic [COL_W-1:0]  col,
  input  logic [DATA_W-1:0] wdata,
  input  logic [1:0]        cfg_bl,
  input  logic              cfg_cl,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_oe
);
  localparam int ADDR_W = BANK_W + COL_W;

  cmd_e              cv;
  logic              en, busy, pipe_busy, idle;
  logic              rd_active, wr_active, start_rd, start_wr;
  logic [ADDR_W-1:0] cur_addr, waddr;
  logic              we, re;
  logic [DATA_W-1:0] rq;

  assign cv       = cmd_e'(cmd);
  assign idle     = ~rd_active & ~wr_active;
  assign start_rd = idle & (cv == CMD_READ);
  assign start_wr = idle & (cv == CMD_WRITE);
  assign busy     = rd_active | wr_active | pipe_busy;
  assign we       = en & (start_wr | wr_active);
  assign re       = en & rd_active;
  assign waddr    = start_wr ? {bank, col} : cur_addr;

  sbe_suspend_gate u_gate (
    .clk(clk), .rst(rst), .cke(cke), .busy(busy), .en(en)
  );

  sbe_burst_ctr #(.BANK_W(BANK_W), .COL_W(COL_W)) u_ctr (
    .clk(clk), .rst(rst), .en(en), .start_rd(start_rd), .start_wr(start_wr),
    .bl_code(cfg_bl), .start_bank(bank), .start_col(col),
    .rd_active(rd_active), .wr_active(wr_active), .cur_addr(cur_addr)
  );

  sbe_cell_array #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_cells (
    .clk(clk), .we(we), .waddr(waddr), .wdata(wdata),
    .re(re), .raddr(cur_addr), .rq(rq)
  );

  sbe_read_pipe #(.DATA_W(DATA_W)) u_pipe (
    .clk(clk), .rst(rst), .en(en), .issue(re), .cl3(cfg_cl), .rq(rq),
    .pipe_busy(pipe_busy), .rdata(rdata), .oe(rdata_oe)
  );

  AST_IDLE_CMD_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (!busy && cv == CMD_READ) |=> rd_active); // R8
endmodule

// File: tb/sim_sdram_burst_core.sv
module sim_sdram_burst_core;
  localparam int DW = 16, BW = 2, CW = 4, NW = 1 << (BW + CW);

  logic          clk = 1'b0, rst = 1'b1, cke = 1'b1, cfg_cl = 1'b0;
  logic [1:0]    cmd = 2'b00, cfg_bl = 2'b00;
  logic [BW-1:0] bank = '0;
  logic [CW-1:0] col = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          rdata_oe;

  logic [DW-1:0] model [NW];
  int vec = 0, bad = 0;

  always #2 clk = ~clk;

  sdram_burst_core #(.DATA_W(DW), .BANK_W(BW), .COL_W(CW)) u0 (
    .clk(clk), .rst(rst), .cke(cke), .cmd(cmd), .bank(bank), .col(col),
    .wdata(wdata), .cfg_bl(cfg_bl), .cfg_cl(cfg_cl),
    .rdata(rdata), .rdata_oe(rdata_oe)
  );

  function automatic int bl_of(input logic [1:0] c); return 1 << c; endfunction
  function automatic int cl_of(input logic c); return c ? 3 : 2; endfunction
  function automatic int wcol(input int c, input int i, input int bl);
    return (c & ~(bl - 1)) | ((c + i) & (bl - 1));
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic junk();
    cmd  = 2'($urandom);
    bank = BW'($urandom);
    col  = CW'($urandom);
  endtask

  task automatic do_read(input int b, input int c, input int pl);
    int bl = bl_of(cfg_bl), cl = cl_of(cfg_cl), k = 0;
    bit nxt, ck;
    logic [DW-1:0] exp [8];
    for (int i = 0; i < bl; i++) exp[i] = model[b * (1 << CW) + wcol(c, i, bl)];
    cmd = 2'b01; bank = BW'(b); col = CW'(c);
    ck = (($urandom % 100) >= pl); cke = ck;
    @(negedge clk); nxt = ck;
    check("R2 oe low after READ", {31'd0, rdata_oe}, 32'd0);
    while (k < cl + bl) begin
      ck = (($urandom % 100) >= pl); cke = ck;
      wdata = DW'($urandom);
      if (!nxt || k < bl) junk(); else cmd = 2'b00;
      @(negedge clk);
      if (nxt) k++;
      nxt = ck;
      if (k >= cl && k < cl + bl) begin
        check("R2 R7 oe during words", {31'd0, rdata_oe}, 32'd1);
        check("R3 R5 R6 read word", {16'd0, rdata}, {16'd0, exp[k - cl]});
      end else begin
        check("R2 oe outside words", {31'd0, rdata_oe}, 32'd0);
      end
    end
    cmd = 2'b00;
  endtask

  task automatic do_write(input int b, input int c, input int pl);
    int bl = bl_of(cfg_bl), i = 1;
    bit nxt, ck;
    logic [DW-1:0] d [8];
    for (int j = 0; j < 8; j++) d[j] = DW'($urandom);
    cmd = 2'b10; bank = BW'(b); col = CW'(c); wdata = d[0];
    ck = (($urandom % 100) >= pl); cke = ck;
    @(negedge clk); nxt = ck;
    model[b * (1 << CW) + c] = d[0];
    check("R4 oe low in write", {31'd0, rdata_oe}, 32'd0);
    while (i < bl) begin
      ck = (($urandom % 100) >= pl); cke = ck;
      junk();
      wdata = nxt ? d[i] : DW'($urandom);
      @(negedge clk);
      if (nxt) begin
        model[b * (1 << CW) + wcol(c, i, bl)] = d[i];
        i++;
      end
      nxt = ck;
      check("R4 oe low in write", {31'd0, rdata_oe}, 32'd0);
    end
    cmd = 2'b00;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    for (int j = 0; j < NW; j++) model[j] = '0;
    repeat (3) @(negedge clk);
    check("R1 oe in reset", {31'd0, rdata_oe}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 oe after reset", {31'd0, rdata_oe}, 32'd0);
    check("R1 rdata after reset", {16'd0, rdata}, 32'd0);

    // Fill the whole array with 8-word bursts.
    cfg_bl = 2'b11;
    for (int j = 0; j < NW / 8; j++) do_write(j / 2, (j % 2) * 8, 0);

    // Every length and latency, free-running and then suspended.
    for (int l = 0; l < 4; l++) begin
      for (int q = 0; q < 2; q++) begin
        cfg_bl = 2'(l); cfg_cl = q[0];
        do_read(int'($urandom % 4), int'($urandom % 16), 0);
        do_read(int'($urandom % 4), 13, 50);
        do_write(int'($urandom % 4), 7, 60);
        do_read(int'($urandom % 4), int'($urandom % 16), 70);
      end
    end

    // R8: cke low while idle, then a command.
    cfg_bl = 2'b10; cfg_cl = 1'b0;
    cke = 1'b0;
    repeat (3) @(negedge clk);
    check("R8 idle oe", {31'd0, rdata_oe}, 32'd0);
    do_write(2, 14, 0);
    cke = 1'b0;
    repeat (2) @(negedge clk);
    do_read(2, 14, 0);

    // Random mix.
    for (int n = 0; n < 160; n++) begin
      int pl;
      cfg_bl = 2'($urandom); cfg_cl = 1'($urandom);
      pl = (n % 3 == 0) ? 0 : ((n % 3 == 1) ? 30 : 70);
      if ($urandom % 2) do_write(int'($urandom % 4), int'($urandom % 16), pl);
      else              do_read(int'($urandom % 4), int'($urandom % 16), pl);
    end

    // Final readback of the whole array (R6: no junk reached it).
    cfg_bl = 2'b11; cfg_cl = 1'b1;
    for (int j = 0; j < NW / 8; j++) do_read(j / 2, (j % 2) * 8, 40);

    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule